// File: doc/BRIEF.md
# Subframe Parity Checker with Sample Concealment

This block sits after the biphase decoder of a digital audio receiver and sees one decoded subframe at a time. The subframe arrives as a word that covers time slots 4 to 31. The block checks that word's parity and hides corrupted audio samples.

When a PCM sample fails the check, the block puts out the last error-free sample of the same channel in its place. When the stream is marked as non-PCM, compressed payloads must never be altered, so a failing word passes through as received. A separate mode mutes the audio whenever non-PCM data arrives. The error flag and the mute indication leave the block together with the sample.

Each strobed subframe produces one result one clock later. The results hold steady between strobes.

Top module: `sfp_conceal`

## Requirements
- R1: While reset is asserted and after it is released, and before the first strobe, out_valid, out_sample, out_right, par_err and muted are all 0.
- R2: The parity check is even over the whole input word. Bits [23:0] are the audio sample, bits [26:24] are the validity, user and channel-status bits, and bit 27 is the parity bit. par_err is 1 exactly when the word holds an odd number of ones. A word with two flipped bits therefore reports no error.
- R3: Each clock edge with sf_valid high gives one out_valid pulse one cycle later. For an error-free subframe that is not muted, out_sample equals bits [23:0] of the word.
- R4: A PCM subframe (non_pcm=0) with a parity error outputs the last good sample stored for its channel. If no good sample has been stored since reset, it outputs 0.
- R5: A channel's stored last-good sample is updated only by error-free PCM subframes of that channel. Errored subframes, non-PCM subframes and subframes of the other channel leave it unchanged.
- R6: A non-PCM subframe with a parity error and mute mode off outputs its received bits [23:0] unchanged.
- R7: When non_pcm and npcm_mute_en are both 1, out_sample is 0 and muted is 1. In every other case muted is 0, so mute mode on its own does not touch PCM data.
- R8: In cycles after an edge without a strobe, out_valid is 0 and out_sample, out_right, par_err and muted keep their values.
- R9: out_right repeats the sf_right value of the strobed subframe, where 1 means right and 0 means left.
- R10: A non-PCM subframe that has a parity error and arrives with mute mode on reports par_err=1 and muted=1 with out_sample=0, all in the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_valid | input | 1 | Strobe for one received subframe |
| sf_word | input | 28 | Subframe slots 4..31: audio [23:0], aux bits [26:24], parity [27] |
| sf_right | input | 1 | Channel of the subframe, 1 = right |
| non_pcm | input | 1 | Stream carries non-PCM data |
| npcm_mute_en | input | 1 | Mute audio while non-PCM data is received |
| out_valid | output | 1 | One-cycle pulse per processed subframe |
| out_sample | output | 24 | Corrected, passed-through or muted sample |
| out_right | output | 1 | Channel of the output sample |
| par_err | output | 1 | Parity error on the reported subframe |
| muted | output | 1 | Output sample is muted |

## Verification
Two functions can land on the same subframe: error reporting and either concealment or muting. A corrupted PCM word has to raise par_err and, in that same result, swap in the stored sample without refreshing the store. A corrupted non-PCM word with mute mode on has to raise par_err and muted together while the sample reads zero. The bench provokes these cases by sweeping every combination of channel, non-PCM flag, mute mode and parity fault over generated samples. It also flips each single bit in turn and then pairs of bits. Every result is compared with a reference model kept in the bench, and a later errored PCM word shows whether the store was changed.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef enum logic [1:0] {
        SRC_LIVE = 2'd0,
        SRC_HELD = 2'd1,
        SRC_ZERO = 2'd2
    } sample_src_e;

endpackage

// File: rtl/sfp_parity.sv
module sfp_parity #(
    parameter int WORD_W = 28
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              odd_o
);
    logic [WORD_W:0] chain;

    assign chain[0] = 1'b0;

    for (genvar gi = 0; gi < WORD_W; gi++) begin : g_fold
        assign chain[gi+1] = chain[gi] ^ word_i[gi];
    end

    assign odd_o = chain[WORD_W];
endmodule

// File: rtl/sfp_hold_bank.sv
module sfp_hold_bank #(
    parameter int SAMPLE_W = 24,
    parameter int NCH      = 2,
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [CH_W-1:0]     wr_ch_i,
    input  logic [SAMPLE_W-1:0] wr_data_i,
    input  logic [CH_W-1:0]     rd_ch_i,
    output logic [SAMPLE_W-1:0] rd_data_o
);
    typedef struct packed {
        logic [NCH-1:0][SAMPLE_W-1:0] slot;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int ci = 0; ci < NCH; ci++) begin
            if (wr_en_i && (wr_ch_i == CH_W'(ci))) begin
                bank_d.slot[ci] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_data_o = bank_q.slot[rd_ch_i];
endmodule

// File: rtl/sfp_select.sv
module sfp_select
    import sfp_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                parity_bad_i,
    input  logic                non_pcm_i,
    input  logic                mute_en_i,
    input  logic [SAMPLE_W-1:0] live_i,
    input  logic [SAMPLE_W-1:0] held_i,
    output logic                mute_o,
    output logic [SAMPLE_W-1:0] sample_o
);
    sample_src_e src;

    always_comb begin
        mute_o = non_pcm_i && mute_en_i;
        if (mute_o) begin
            src = SRC_ZERO;
        end else if (parity_bad_i && !non_pcm_i) begin
            src = SRC_HELD;
        end else begin
            src = SRC_LIVE;
        end
        case (src)
            SRC_HELD: sample_o = held_i;
            SRC_ZERO: sample_o = '0;
            default:  sample_o = live_i;
        endcase
    end
endmodule

// File: rtl/sfp_conceal.sv
module sfp_conceal
    import sfp_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int AUX_W    = 3,
    localparam int WORD_W  = SAMPLE_W + AUX_W + 1,
    localparam int NCH     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sf_valid,
    input  logic [WORD_W-1:0]   sf_word,
    input  logic                sf_right,
    input  logic                non_pcm,
    input  logic                npcm_mute_en,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                out_right,
    output logic                par_err,
    output logic                muted
);
    typedef struct packed {
        logic                valid;
        logic [SAMPLE_W-1:0] sample;
        logic                right;
        logic                err;
        logic                muted;
    } res_t;

    res_t res_d, res_q;

    logic                odd;
    logic                keep_good;
    logic                mute_now;
    logic [SAMPLE_W-1:0] held;
    logic [SAMPLE_W-1:0] picked;
    chan_e               chan;

    assign chan = chan_e'(sf_right);

    sfp_parity #(
        .WORD_W (WORD_W)
    ) u_parity (
        .word_i (sf_word),
        .odd_o  (odd)
    );

    assign keep_good = sf_valid && !odd && !non_pcm;

    sfp_hold_bank #(
        .SAMPLE_W (SAMPLE_W),
        .NCH      (NCH)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (keep_good),
        .wr_ch_i   (chan),
        .wr_data_i (sf_word[SAMPLE_W-1:0]),
        .rd_ch_i   (chan),
        .rd_data_o (held)
    );

    sfp_select #(
        .SAMPLE_W (SAMPLE_W)
    ) u_select (
        .parity_bad_i (odd),
        .non_pcm_i    (non_pcm),
        .mute_en_i    (npcm_mute_en),
        .live_i       (sf_word[SAMPLE_W-1:0]),
        .held_i       (held),
        .mute_o       (mute_now),
        .sample_o     (picked)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (sf_valid) begin
            res_d.valid  = 1'b1;
            res_d.sample = picked;
            res_d.right  = (chan == CH_RIGHT);
            res_d.err    = odd;
            res_d.muted  = mute_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid  = res_q.valid;
    assign out_sample = res_q.sample;
    assign out_right  = res_q.right;
    assign par_err    = res_q.err;
    assign muted      = res_q.muted;
endmodule

// File: rtl/sfp_checker.sv
module sfp_checker #(
    parameter int SAMPLE_W = 24,
    parameter int WORD_W   = 28
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sf_valid,
    input logic [WORD_W-1:0]   sf_word,
    input logic                sf_right,
    input logic                non_pcm,
    input logic                npcm_mute_en,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_sample,
    input logic                out_right,
    input logic                par_err,
    input logic                muted
);
    p_parity_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sf_valid |=> (par_err == $past(^sf_word)));

    p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sf_valid |=> out_valid);

    p_npcm_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_valid && non_pcm && !npcm_mute_en) |=>
            (out_sample == $past(sf_word[SAMPLE_W-1:0])));

    p_mute_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_valid && non_pcm && npcm_mute_en) |=> (muted && (out_sample == '0)));

    p_no_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_valid && !(non_pcm && npcm_mute_en)) |=> !muted);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sf_valid |=> (!out_valid && $stable(out_sample) && $stable(par_err) && $stable(muted) && $stable(out_right)));

    p_channel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sf_valid |=> (out_right == $past(sf_right)));
endmodule

bind sfp_conceal sfp_checker #(
    .SAMPLE_W (SAMPLE_W),
    .WORD_W   (WORD_W)
) u_sfp_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sf_valid     (sf_valid),
    .sf_word      (sf_word),
    .sf_right     (sf_right),
    .non_pcm      (non_pcm),
    .npcm_mute_en (npcm_mute_en),
    .out_valid    (out_valid),
    .out_sample   (out_sample),
    .out_right    (out_right),
    .par_err      (par_err),
    .muted        (muted)
);

// File: tb/test_sfp_conceal.sv
module test_sfp_conceal;
    localparam int SW = 24;
    localparam int WW = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sf_valid = 1'b0;
    logic [WW-1:0] sf_word = '0;
    logic          sf_right = 1'b0;
    logic          non_pcm = 1'b0;
    logic          npcm_mute_en = 1'b0;
    logic          out_valid;
    logic [SW-1:0] out_sample;
    logic          out_right;
    logic          par_err;
    logic          muted;

    int unsigned tests = 0;
    int unsigned fails = 0;
    bit          done = 1'b0;
    logic [31:0] lcg = 32'h1234_5678;
    logic [SW-1:0] model_lg [2];
    logic [SW-1:0] last_exp = '0;

    always #5 clk = ~clk;

    sfp_conceal i_sfp_conceal (
        .clk          (clk),
        .rst_n        (rst_n),
        .sf_valid     (sf_valid),
        .sf_word      (sf_word),
        .sf_right     (sf_right),
        .non_pcm      (non_pcm),
        .npcm_mute_en (npcm_mute_en),
        .out_valid    (out_valid),
        .out_sample   (out_sample),
        .out_right    (out_right),
        .par_err      (par_err),
        .muted        (muted)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg;
    endfunction

    // good word: 24-bit sample plus aux bits, parity bit 27 makes the one count even
    function automatic logic [WW-1:0] good_word(input logic [SW-1:0] s, input logic [2:0] aux);
        logic [WW-2:0] body;
        body = {aux, s};
        return {^body, body};
    endfunction

    task automatic send(input logic [WW-1:0] w, input logic rt, input logic np, input logic me, input string tag);
        logic          e_err;
        logic          e_mut;
        logic [SW-1:0] e_smp;
        e_err = ^w;
        e_mut = np && me;
        if (e_mut)              e_smp = '0;
        else if (e_err && !np)  e_smp = model_lg[rt];
        else                    e_smp = w[SW-1:0];
        @(negedge clk);
        sf_word = w; sf_right = rt; non_pcm = np; npcm_mute_en = me; sf_valid = 1'b1;
        @(negedge clk);
        sf_valid = 1'b0;
        check({tag, " R3 out_valid"}, 32'(out_valid), 32'd1);
        check({tag, " R2 par_err"}, 32'(par_err), 32'(e_err));
        check({tag, " R4/R6 sample"}, 32'(out_sample), 32'(e_smp));
        check({tag, " R7 muted"}, 32'(muted), 32'(e_mut));
        check({tag, " R9 channel"}, 32'(out_right), 32'(rt));
        if (!e_err && !np) model_lg[rt] = w[SW-1:0];
        last_exp = e_smp;
        @(negedge clk);
        check({tag, " R8 idle valid"}, 32'(out_valid), 32'd0);
        check({tag, " R8 idle sample"}, 32'(out_sample), 32'(e_smp));
        check({tag, " R8 idle flag"}, 32'(par_err), 32'(e_err));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [WW-1:0] w;
        model_lg[0] = '0;
        model_lg[1] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", 32'(out_valid), 32'd0);
        check("R1 sample", 32'(out_sample), 32'd0);
        check("R1 err", 32'(par_err), 32'd0);
        check("R1 muted", 32'(muted), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 32'({out_valid, out_right, par_err, muted}), 32'd0);

        // R4 errored PCM before any good sample: zero from the store
        w = good_word(24'hABCDEF, 3'b101) ^ 28'h1;
        send(w, 1'b0, 1'b0, 1'b0, "R4 empty store");

        // R2 single and double flips on each channel
        for (int ch = 0; ch < 2; ch++) begin
            send(good_word(24'h5A5A00 + 24'(ch), 3'b010), ch[0], 1'b0, 1'b0, "R3 seed");
            for (int pos = 0; pos < WW; pos++) begin
                send(good_word(24'h5A5A00 + 24'(ch), 3'b010) ^ (28'h1 << pos), ch[0], 1'b0, 1'b0, "R2 single flip");
            end
            for (int pos = 0; pos < WW - 1; pos++) begin
                send(good_word(24'(rnd()), 3'(rnd())) ^ (28'h3 << pos), ch[0], 1'b0, 1'b0, "R2 double flip");
            end
        end

        // R5 store touched only by good PCM of its own channel
        send(good_word(24'h111111, 3'b000), 1'b0, 1'b0, 1'b0, "R5 good left");
        send(good_word(24'h222222, 3'b000), 1'b0, 1'b1, 1'b0, "R5 npcm left");
        send(good_word(24'h333333, 3'b000), 1'b1, 1'b0, 1'b0, "R5 good right");
        send(good_word(24'h444444, 3'b000) ^ 28'h10, 1'b0, 1'b0, 1'b0, "R5 bad left");
        check("R5 left store kept", 32'(out_sample), 32'h111111);

        // R10 error and mute on one subframe
        send(good_word(24'h777777, 3'b111) ^ 28'h100, 1'b1, 1'b1, 1'b1, "R10 err+mute");
        check("R10 err", 32'(par_err), 32'd1);
        check("R10 muted", 32'(muted), 32'd1);

        // full sweep of channel, non-PCM, mute mode, fault
        for (int rep = 0; rep < 12; rep++) begin
            for (int combo = 0; combo < 16; combo++) begin
                logic [31:0] r;
                r = rnd();
                w = good_word(r[23:0], r[26:24]);
                if (combo[3]) w = w ^ (28'h1 << (r[31:27] % WW));
                send(w, combo[0], combo[1], combo[2], "sweep R6 R7");
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule